// File: doc/BRIEF.md
# Trap Handler Address Generator

This block produces the program counter at which a hart resumes when it takes a trap. It receives the trap-vector register, the exception cause code, the interrupt identity and a flag that turns on table-driven dispatch. It then returns the handler address together with a one-cycle valid strobe. The two low bits of the trap-vector register select the dispatch style. Clearing those bits gives a base address that is always aligned to four bytes.

Direct dispatch and plain vectored dispatch are pure address arithmetic. The result is ready one cycle after the request. Table-driven dispatch instead reads one XLEN-bit word from a table in memory, indexed by the interrupt identity. It clears the low bits of that word according to the instruction alignment and hands the result out as the new PC. A failed table read raises a fault strobe instead of a PC. The block issues one request at a time through a valid/ready request channel and accepts a response that carries data and an error bit.

Top module: `trap_vec_gen`

## Requirements
- R1: After reset, pc_valid, fault, mem_req_valid and busy are all low.
- R2: When the mode field tvec[1:0] is 00, pc_valid pulses in the cycle after trap_req is accepted, and pc_out equals tvec with bits 1:0 cleared. No memory request is made, even when table_en is high.
- R3: When the mode field is 01 and table_en is low, pc_out equals the base plus four times the cause code, wrapping modulo 2^XLEN, one cycle after acceptance.
- R4: The reserved mode values 10 and 11 behave exactly like mode 00, whatever the value of table_en.
- R5: When the mode field is 01 and table_en is high, the block raises mem_req_valid with mem_req_addr equal to the base plus (XLEN/8) times irq_id. Valid and address stay stable until mem_req_ready is seen high.
- R6: A fetched table entry is loaded into pc_out with bit 0 cleared when IALIGN is 16, and with bits 1:0 cleared when IALIGN is 32. pc_valid pulses in the cycle after the response.
- R7: A response with mem_rsp_err high produces a one-cycle fault pulse and no pc_valid pulse.
- R8: pc_valid and fault are never high together, and each lasts exactly one cycle.
- R9: trap_req is ignored while busy is high. It causes no extra request and no extra output pulse.
- R10: Each table-driven trap issues exactly one request. mem_req_valid is low in the cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Start a handler-address computation (taken only when idle) |
| tvec | input | XLEN | Trap-vector register value; bits 1:0 are the mode |
| cause | input | CAUSE_W | Exception cause code |
| irq_id | input | ID_W | Interrupt identity, used as the table index |
| table_en | input | 1 | Selects table-driven dispatch for vectored mode |
| busy | output | 1 | A computation is in progress |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | XLEN | Table entry address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | XLEN | Read response word |
| mem_rsp_err | input | 1 | Read response signals a fault |
| pc_valid | output | 1 | One-cycle strobe: pc_out holds the handler address |
| pc_out | output | XLEN | Handler program counter |
| fault | output | 1 | One-cycle strobe: the table fetch failed |

## Verification
Suppose the sequencer were left in a wrong state. The next trap would show it at once: a result strobe would appear in the wrong cycle, a request would be missing or repeated, or busy would stay high after a completed fetch. The bench checks the exact cycle of every strobe and the idle state that follows, so such an error shows up within one or two cycles of the trap. A wrong address or a wrong mask shows up on mem_req_addr or pc_out in the single cycle where the strobe or the request is visible. The bench samples those values in exactly that cycle.

// File: rtl/tvg_pkg.sv
// Package: shared types for the trap handler address generator.
// Assumes: nothing beyond IEEE 1800-2017.
package tvg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } tvg_state_e;

    localparam logic [1:0] MODE_DIRECT = 2'b00;
    localparam logic [1:0] MODE_VECTOR = 2'b01;

endpackage

// File: rtl/tvg_addr_calc.sv
// Module: tvg_addr_calc
// Computes, combinationally, either the final handler address (direct or
// plain vectored) or the table entry address (table-driven vectored).
// Assumes: CAUSE_W and ID_W are below XLEN; XLEN is 32 or 64.
module tvg_addr_calc #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6,
    parameter int ID_W    = 10
) (
    input  logic [XLEN-1:0]    tvec,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [ID_W-1:0]    irq_id,
    input  logic               table_en,
    output logic [XLEN-1:0]    target,
    output logic               use_table
);
    import tvg_pkg::*;

    localparam int ENTRY_SHIFT = $clog2(XLEN / 8);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] vec_addr;
    logic [XLEN-1:0] tbl_addr;
    logic [1:0]      mode;

    // Split the register into its aligned base and its mode field.
    always_comb begin
        mode = tvec[1:0];
        base = {tvec[XLEN-1:2], 2'b00};
    end

    // Offsets for plain vectored and table-driven dispatch.
    always_comb begin
        vec_addr = base + (XLEN'(cause) << 2);
        tbl_addr = base + (XLEN'(irq_id) << ENTRY_SHIFT);
    end

    // Select the result; reserved modes fall back to direct.
    always_comb begin
        use_table = 1'b0;
        target    = base;
        if (mode == MODE_VECTOR) begin
            if (table_en) begin
                use_table = 1'b1;
                target    = tbl_addr;
            end else begin
                target    = vec_addr;
            end
        end
    end

endmodule

// File: rtl/tvg_entry_mask.sv
// Module: tvg_entry_mask
// Clears the low bits of a fetched table entry according to the
// instruction alignment.
// Assumes: IALIGN is 16 or 32; any other value is treated as 32.
module tvg_entry_mask #(
    parameter int XLEN   = 32,
    parameter int IALIGN = 32
) (
    input  logic [XLEN-1:0] entry,
    output logic [XLEN-1:0] masked
);
    localparam int LOW_BITS = (IALIGN == 16) ? 1 : 2;

    generate
        if (LOW_BITS == 1) begin : g_align16
            // Drop bit 0 only.
            always_comb masked = {entry[XLEN-1:1], 1'b0};
        end else begin : g_align32
            // Drop bits 1:0.
            always_comb masked = {entry[XLEN-1:2], 2'b00};
        end
    endgenerate

endmodule

// File: rtl/tvg_fetch_fsm.sv
// Module: tvg_fetch_fsm
// Sequencer: idle -> (request -> wait ->) done -> idle. It drives the
// request valid and the one-cycle result strobes.
// Assumes: at most one outstanding request; a response arrives only after
// the request handshake.
module tvg_fetch_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic use_table,
    input  logic req_ready,
    input  logic rsp_valid,
    input  logic rsp_err,
    output logic accept,
    output logic rsp_take,
    output logic req_valid,
    output logic busy,
    output logic pc_valid,
    output logic fault
);
    import tvg_pkg::*;

    tvg_state_e state_q, state_d;
    logic       fault_q, fault_d;

    // Next-state and handshake decode.
    always_comb begin
        state_d  = state_q;
        fault_d  = fault_q;
        accept   = 1'b0;
        rsp_take = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    accept  = 1'b1;
                    fault_d = 1'b0;
                    state_d = use_table ? ST_REQ : ST_DONE;
                end
            end
            ST_REQ: begin
                if (req_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    rsp_take = 1'b1;
                    fault_d  = rsp_err;
                    state_d  = ST_DONE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State and fault flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        req_valid = (state_q == ST_REQ);
        busy      = (state_q != ST_IDLE);
        pc_valid  = (state_q == ST_DONE) && !fault_q;
        fault     = (state_q == ST_DONE) && fault_q;
    end

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_valid && fault));
    // R8
    pc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |=> !pc_valid);
    // R7
    fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(rsp_valid && rsp_err));
    // R10
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

endmodule

// File: rtl/trap_vec_gen.sv
// Module: trap_vec_gen (top)
// Produces the trap handler PC from the trap-vector register, the cause and
// the interrupt identity. For table dispatch it fetches the entry from memory.
// Assumes: the memory answers each accepted request with exactly one
// response; XLEN is 32 or 64; IALIGN is 16 or 32.
module trap_vec_gen #(
    parameter int XLEN    = 32,
    parameter int IALIGN  = 32,
    parameter int CAUSE_W = 6,
    parameter int ID_W    = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_req,
    input  logic [XLEN-1:0]    tvec,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [ID_W-1:0]    irq_id,
    input  logic               table_en,
    output logic               busy,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [XLEN-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [XLEN-1:0]    mem_rsp_data,
    input  logic               mem_rsp_err,
    output logic               pc_valid,
    output logic [XLEN-1:0]    pc_out,
    output logic               fault
);
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] masked;
    logic            use_table;
    logic            accept;
    logic            rsp_take;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] pc_q;

    tvg_addr_calc #(
        .XLEN(XLEN), .CAUSE_W(CAUSE_W), .ID_W(ID_W)
    ) calc_i (
        .tvec(tvec), .cause(cause), .irq_id(irq_id), .table_en(table_en),
        .target(target), .use_table(use_table)
    );

    tvg_entry_mask #(.XLEN(XLEN), .IALIGN(IALIGN)) mask_i (
        .entry(mem_rsp_data), .masked(masked)
    );

    tvg_fetch_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .start(trap_req), .use_table(use_table),
        .req_ready(mem_req_ready), .rsp_valid(mem_rsp_valid),
        .rsp_err(mem_rsp_err), .accept(accept), .rsp_take(rsp_take),
        .req_valid(mem_req_valid), .busy(busy), .pc_valid(pc_valid),
        .fault(fault)
    );

    // Capture the table address at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= target;
    end

    // Capture the handler PC from arithmetic or from a good fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pc_q <= '0;
        else if (accept && !use_table)       pc_q <= target;
        else if (rsp_take && !mem_rsp_err)   pc_q <= masked;
    end

    assign mem_req_addr = addr_q;
    assign pc_out       = pc_q;

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // R6
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |-> (pc_out[1:0] == 2'b00 || (IALIGN == 16 && pc_out[0] == 1'b0)));
    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pc_valid && !fault) |=> busy);

endmodule

// File: tb/trap_vec_gen_tb.sv
module trap_vec_gen_tb_top;
    localparam int XLEN    = 32;
    localparam int CAUSE_W = 6;
    localparam int ID_W    = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               trap_req = 1'b0;
    logic [XLEN-1:0]    tvec = '0;
    logic [CAUSE_W-1:0] cause = '0;
    logic [ID_W-1:0]    irq_id = '0;
    logic               table_en = 1'b0;
    logic               busy;
    logic               mem_req_valid;
    logic               mem_req_ready = 1'b0;
    logic [XLEN-1:0]    mem_req_addr;
    logic               mem_rsp_valid = 1'b0;
    logic [XLEN-1:0]    mem_rsp_data = '0;
    logic               mem_rsp_err = 1'b0;
    logic               pc_valid;
    logic [XLEN-1:0]    pc_out;
    logic               fault;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trap_vec_gen #(.XLEN(XLEN), .IALIGN(32), .CAUSE_W(CAUSE_W), .ID_W(ID_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .tvec(tvec),
        .cause(cause), .irq_id(irq_id), .table_en(table_en), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .pc_valid(pc_valid), .pc_out(pc_out), .fault(fault)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Start a trap for one cycle; returns at the negedge after acceptance.
    task automatic fire(input logic [XLEN-1:0] tv, input logic [CAUSE_W-1:0] c,
                        input logic [ID_W-1:0] id, input logic ten);
        @(negedge clk);
        tvec = tv; cause = c; irq_id = id; table_en = ten; trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
    endtask

    // Arithmetic path: the result strobe is due one cycle after acceptance.
    task automatic t_arith(input string req, input logic [XLEN-1:0] tv,
                           input logic [CAUSE_W-1:0] c, input logic ten,
                           input logic [XLEN-1:0] exp_pc);
        fire(tv, c, 10'd7, ten);
        chk({req, " pc_valid"}, 64'(pc_valid), 64'd1);
        chk({req, " pc_out"}, 64'(pc_out), 64'(exp_pc));
        chk({req, " no request"}, 64'(mem_req_valid), 64'd0);
        @(negedge clk);
        chk({req, " R8 pulse ends"}, 64'(pc_valid), 64'd0);
        chk({req, " idle"}, 64'(busy), 64'd0);
    endtask

    // Table path with a ready stall, an ignored trap_req while busy and a response.
    task automatic t_table(input logic [XLEN-1:0] tv, input logic [ID_W-1:0] id,
                           input logic [XLEN-1:0] word, input logic err);
        logic [XLEN-1:0] exp_addr;
        exp_addr = {tv[XLEN-1:2], 2'b00} + (XLEN'(id) << 2);
        fire(tv, 6'd3, id, 1'b1);
        chk("R5 request raised", 64'(mem_req_valid), 64'd1);
        chk("R5 request address", 64'(mem_req_addr), 64'(exp_addr));
        @(negedge clk);
        chk("R5 request held", 64'(mem_req_valid), 64'd1);
        chk("R5 address held", 64'(mem_req_addr), 64'(exp_addr));
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R10 request dropped", 64'(mem_req_valid), 64'd0);
        trap_req = 1'b1; tvec = 32'h0000_4000; table_en = 1'b0;
        @(negedge clk);
        trap_req = 1'b0;
        chk("R9 no pulse while busy", 64'(pc_valid | fault), 64'd0);
        chk("R9 still busy", 64'(busy), 64'd1);
        mem_rsp_valid = 1'b1; mem_rsp_data = word; mem_rsp_err = err;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
        if (err) begin
            chk("R7 fault pulse", 64'(fault), 64'd1);
            chk("R7 no pc_valid", 64'(pc_valid), 64'd0);
        end else begin
            chk("R6 pc_valid", 64'(pc_valid), 64'd1);
            chk("R6 masked entry", 64'(pc_out), 64'({word[XLEN-1:2], 2'b00}));
            chk("R6 no fault", 64'(fault), 64'd0);
        end
        @(negedge clk);
        chk("R8 strobes end", 64'(pc_valid | fault), 64'd0);
        chk("R9 back to idle", 64'(busy), 64'd0);
        chk("R10 no second request", 64'(mem_req_valid), 64'd0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 pc_valid", 64'(pc_valid), 64'd0);
        chk("R1 fault", 64'(fault), 64'd0);
        chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk("R1 busy", 64'(busy), 64'd0);

        t_arith("R2 direct", 32'h8000_1000, 6'd5, 1'b0, 32'h8000_1000);
        t_arith("R2 direct table_en", 32'h2000_0100, 6'd9, 1'b1, 32'h2000_0100);
        t_arith("R3 vectored", 32'h8000_0001, 6'd11, 1'b0, 32'h8000_002C);
        t_arith("R3 vectored wrap", 32'hFFFF_FF01, 6'd63, 1'b0, 32'hFFFF_FFFC);
        t_arith("R4 reserved 10", 32'h1234_5602, 6'd4, 1'b1, 32'h1234_5600);
        t_arith("R4 reserved 11", 32'h1234_5603, 6'd4, 1'b0, 32'h1234_5600);

        t_table(32'h0001_0001, 10'd5, 32'h4000_1237, 1'b0);
        t_table(32'h0002_0001, 10'd1023, 32'hDEAD_BEEF, 1'b1);
        t_table(32'h0003_0001, 10'd0, 32'h8765_4322, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule